// File: doc/BRIEF.md
# Mixed-Operand Significand Pre-Normalizer

This unit sits in front of a far/close-path floating-point adder and turns two raw single-precision operands into 33-bit prepared words. Each prepared word is the sign, an 8-bit exponent field, an explicit leading significand bit and the 23-bit fraction. When both operands are normal, the leading bit is 1 and everything else passes through. When exactly one operand is denormal (a "mixed" pair), the unit counts the leading zeros of the denormal's 24-bit significand. It shifts that significand left until its top bit is 1 and writes the shift count into the exponent field. A mixed flag tells the adder to read that field as an extra negative offset. The prepared denormal then stands for 1.f × 2^(-126-k), and no fraction bits are lost when the adder aligns it.

The upstream classifier supplies a per-operand flag: 1 means normal, 0 means denormal. A denormal presented to this unit always has a nonzero fraction, so the shift count k lies between 1 and 23. The unit registers its result once. It accepts a new pair on every cycle that `inValid` is high and holds its last result otherwise. Operand order and sign bits are never exchanged.

Top module: `mixed_prenorm`

## Requirements
- R1: `outValid` is high in exactly the cycle after a cycle in which `inValid` was high, and low otherwise.
- R2: While `rstN` is low, `outValid`, `mixedFlag`, `prepA` and `prepB` are all zero.
- R3: Bit 32 of each prepared word equals bit 31 of the matching operand (A to A, B to B).
- R4: With both type flags 1, each prepared word is {op[31], op[30:23], 1'b1, op[22:0]} and `mixedFlag` is 0.
- R5: `mixedFlag` is 1 exactly when one type flag is 1 and the other is 0, for the pair accepted last.
- R6: In a mixed pair, the normal operand's prepared word has the R4 layout.
- R7: In a mixed pair, the denormal operand's word is {sign, k as 8 bits, s[23:0]}. Here s is {1'b0, fraction} shifted left by k, and k is the smallest shift that makes s[23] equal 1.
- R8: The shift count reaches both ends of its range: a fraction with bit 22 set gives k = 1, and a fraction equal to 1 gives k = 23.
- R9: With both type flags 0, each prepared word is {op[31], op[30:23], 1'b0, op[22:0]}, unshifted, and `mixedFlag` is 0.
- R10: In a cycle with `inValid` low, `prepA`, `prepB` and `mixedFlag` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand pair is present this cycle |
| opA | input | 32 | Raw operand A |
| opB | input | 32 | Raw operand B |
| aNormal | input | 1 | 1 if A is normal, 0 if A is denormal |
| bNormal | input | 1 | 1 if B is normal, 0 if B is denormal |
| outValid | output | 1 | Prepared words are fresh |
| prepA | output | 33 | Prepared word for A |
| prepB | output | 33 | Prepared word for B |
| mixedFlag | output | 1 | Exponent of the shifted operand is a negative offset |

## Verification
A wrong leading-zero count or shifter stage would show at the ports one cycle after the pair is accepted. It would appear as an exponent field that is not k, a leading bit of 0, or a fraction whose bits are displaced. A decode fault that swaps the shifted operand or gives the wrong leading bit shows in the same cycle in the other word or in `mixedFlag`. A faulty load enable shows in the first idle cycle, when the held words change.

// File: rtl/pnrm_pkg.sv
package pnrm_pkg;
  // Strobes from control to datapath for one accepted pair
  typedef struct packed {
    logic load;    // capture new prepared words
    logic normA;   // implicit bit for A
    logic normB;   // implicit bit for B
    logic shiftA;  // A is the denormal of a mixed pair
    logic shiftB;  // B is the denormal of a mixed pair
    logic mixed;   // exactly one operand normal
  } pnrmStrobe_t;
endpackage

// File: rtl/pnrm_lzc.sv
module pnrm_lzc #(
  parameter int SIG_W = 24,
  parameter int CNT_W = $clog2(SIG_W + 1)
) (
  input  logic [SIG_W-1:0] sigIn,
  output logic [CNT_W-1:0] zeroCnt
);
  logic seenOne;

  // Leading-one search from the MSB down
  always_comb begin
    zeroCnt = '0;
    seenOne = 1'b0;
    for (int i = SIG_W - 1; i >= 0; i--) begin
      if (!seenOne) begin
        if (sigIn[i]) seenOne = 1'b1;
        else          zeroCnt = zeroCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pnrm_shifter.sv
module pnrm_shifter #(
  parameter int SIG_W = 24,
  parameter int CNT_W = $clog2(SIG_W + 1)
) (
  input  logic [SIG_W-1:0] sigIn,
  input  logic [CNT_W-1:0] shiftAmt,
  output logic [SIG_W-1:0] sigOut
);
  logic [SIG_W-1:0] stage [0:CNT_W];

  assign stage[0] = sigIn;

  // Logarithmic left shifter: stage g moves by 2**g when that bit is set
  for (genvar g = 0; g < CNT_W; g++) begin : gStage
    localparam int STEP = 2 ** g;
    assign stage[g+1] = shiftAmt[g] ? (stage[g] << STEP) : stage[g];
  end

  assign sigOut = stage[CNT_W];
endmodule

// File: rtl/pnrm_ctrl.sv
module pnrm_ctrl
  import pnrm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        aNormal,
  input  logic        bNormal,
  output pnrmStrobe_t strobe,
  output logic        outValid,
  output logic        mixedFlag
);
  always_comb begin
    strobe.load   = inValid;
    strobe.normA  = aNormal;
    strobe.normB  = bNormal;
    strobe.mixed  = aNormal ^ bNormal;
    strobe.shiftA = !aNormal && bNormal;
    strobe.shiftB = aNormal && !bNormal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      mixedFlag <= 1'b0;
    end else begin
      outValid <= inValid;
      if (strobe.load) mixedFlag <= strobe.mixed;
    end
  end
endmodule

// File: rtl/pnrm_datapath.sv
module pnrm_datapath
  import pnrm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pnrmStrobe_t             strobe,
  input  logic [EXP_W+FRAC_W:0]   opA,
  input  logic [EXP_W+FRAC_W:0]   opB,
  output logic [EXP_W+FRAC_W+1:0] prepA,
  output logic [EXP_W+FRAC_W+1:0] prepB
);
  localparam int SIG_W  = FRAC_W + 1;
  localparam int CNT_W  = $clog2(SIG_W + 1);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int PREP_W = WORD_W + 1;
  localparam int SGN    = WORD_W - 1;

  logic [SIG_W-1:0]  denSig, normSig;
  logic [CNT_W-1:0]  lzCnt;
  logic [EXP_W-1:0]  offsetExp;
  logic [PREP_W-1:0] wordA, wordB;

  // Only one operand of a mixed pair is denormal: share one counter/shifter
  assign denSig = strobe.shiftA ? {1'b0, opA[FRAC_W-1:0]} : {1'b0, opB[FRAC_W-1:0]};

  pnrm_lzc #(.SIG_W(SIG_W), .CNT_W(CNT_W)) u_lzc (
    .sigIn  (denSig),
    .zeroCnt(lzCnt)
  );

  pnrm_shifter #(.SIG_W(SIG_W), .CNT_W(CNT_W)) u_shift (
    .sigIn   (denSig),
    .shiftAmt(lzCnt),
    .sigOut  (normSig)
  );

  assign offsetExp = {{(EXP_W-CNT_W){1'b0}}, lzCnt};

  always_comb begin
    if (strobe.shiftA)
      wordA = {opA[SGN], offsetExp, normSig};
    else
      wordA = {opA[SGN], opA[SGN-1:FRAC_W], strobe.normA, opA[FRAC_W-1:0]};
    if (strobe.shiftB)
      wordB = {opB[SGN], offsetExp, normSig};
    else
      wordB = {opB[SGN], opB[SGN-1:FRAC_W], strobe.normB, opB[FRAC_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prepA <= '0;
      prepB <= '0;
    end else if (strobe.load) begin
      prepA <= wordA;
      prepB <= wordB;
    end
  end
endmodule

// File: rtl/mixed_prenorm.sv
module mixed_prenorm
  import pnrm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [EXP_W+FRAC_W:0]   opA,
  input  logic [EXP_W+FRAC_W:0]   opB,
  input  logic                    aNormal,
  input  logic                    bNormal,
  output logic                    outValid,
  output logic [EXP_W+FRAC_W+1:0] prepA,
  output logic [EXP_W+FRAC_W+1:0] prepB,
  output logic                    mixedFlag
);
  pnrmStrobe_t strobe;

  pnrm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .aNormal  (aNormal),
    .bNormal  (bNormal),
    .strobe   (strobe),
    .outValid (outValid),
    .mixedFlag(mixedFlag)
  );

  pnrm_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .opA   (opA),
    .opB   (opB),
    .prepA (prepA),
    .prepB (prepB)
  );
endmodule

// File: rtl/mixed_prenorm_chk.sv
module mixed_prenorm_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic [EXP_W+FRAC_W:0]   opA,
  input logic [EXP_W+FRAC_W:0]   opB,
  input logic                    aNormal,
  input logic                    bNormal,
  input logic                    outValid,
  input logic [EXP_W+FRAC_W+1:0] prepA,
  input logic [EXP_W+FRAC_W+1:0] prepB,
  input logic                    mixedFlag
);
  localparam int TOP = EXP_W + FRAC_W + 1;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) inValid |=> outValid);  // R1
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> !outValid);  // R1
  AST_SIGN_A: assert property (@(posedge clk) disable iff (!rstN) inValid |=> prepA[TOP] == $past(opA[TOP-1]));  // R3
  AST_SIGN_B: assert property (@(posedge clk) disable iff (!rstN) inValid |=> prepB[TOP] == $past(opB[TOP-1]));  // R3
  AST_MIXED_DECODE: assert property (@(posedge clk) disable iff (!rstN) inValid |=> mixedFlag == $past(aNormal ^ bNormal));  // R5
  AST_MIXED_LEAD_ONE: assert property (@(posedge clk) disable iff (!rstN) (outValid && mixedFlag) |-> (prepA[FRAC_W] && prepB[FRAC_W]));  // R7
  AST_BOTH_NORMAL_LEAD: assert property (@(posedge clk) disable iff (!rstN) (inValid && aNormal && bNormal) |=> (prepA[FRAC_W] && prepB[FRAC_W] && !mixedFlag));  // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> ($stable(prepA) && $stable(prepB) && $stable(mixedFlag)));  // R10
endmodule

bind mixed_prenorm mixed_prenorm_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
  .aNormal(aNormal), .bNormal(bNormal), .outValid(outValid),
  .prepA(prepA), .prepB(prepB), .mixedFlag(mixedFlag)
);

// File: tb/mixed_prenorm_tb.sv
module mixed_prenorm_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        aNormal = 1'b0, bNormal = 1'b0;
  logic        outValid, mixedFlag;
  logic [32:0] prepA, prepB;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mixed_prenorm u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .aNormal(aNormal), .bNormal(bNormal), .outValid(outValid),
    .prepA(prepA), .prepB(prepB), .mixedFlag(mixedFlag)
  );

  // Reference model state
  logic [32:0] expA = '0, expB = '0;
  logic        expValid = 1'b0, expMixed = 1'b0;
  string       tagA = "R2", tagB = "R2";
  int          kA = 0, kB = 0;

  function automatic int leadShift(logic [22:0] frac);
    int sig = int'(frac);
    int k = 0;
    while (sig < 8388608) begin
      sig = sig * 2;
      k++;
    end
    return k;
  endfunction

  function automatic logic [32:0] refWord(logic [31:0] op, bit isNorm, bit doShift);
    int k;
    logic [23:0] sig;
    if (!doShift) return {op[31], op[30:23], isNorm, op[22:0]};
    k = leadShift(op[22:0]);
    sig = {1'b0, op[22:0]} << k;
    return {op[31], 8'(k), sig};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      expValid <= 1'b0; expMixed <= 1'b0; expA <= '0; expB <= '0;
      tagA <= "R2"; tagB <= "R2"; kA <= 0; kB <= 0;
    end else begin
      expValid <= inValid;
      if (inValid) begin
        expMixed <= aNormal ^ bNormal;
        expA <= refWord(opA, aNormal, !aNormal && bNormal);
        expB <= refWord(opB, bNormal, aNormal && !bNormal);
        kA <= (!aNormal && bNormal) ? leadShift(opA[22:0]) : 0;
        kB <= (aNormal && !bNormal) ? leadShift(opB[22:0]) : 0;
        tagA <= (aNormal && bNormal) ? "R4" : (!aNormal && !bNormal) ? "R9" : aNormal ? "R6" : "R7";
        tagB <= (aNormal && bNormal) ? "R4" : (!aNormal && !bNormal) ? "R9" : bNormal ? "R6" : "R7";
      end else begin
        tagA <= "R10"; tagB <= "R10"; kA <= 0; kB <= 0;
      end
    end
  end

  task automatic check(string tag, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare every clock, 2 ns after the rising edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      check(rstN ? "R1" : "R2", 33'(outValid), 33'(expValid));
      check(rstN ? "R5" : "R2", 33'(mixedFlag), 33'(expMixed));
      check(tagA, prepA, expA);
      check(tagB, prepB, expB);
      if (rstN && expValid) begin
        check("R3", 33'(prepA[32]), 33'(expA[32]));
        check("R3", 33'(prepB[32]), 33'(expB[32]));
      end
      // R8: range ends of the shift count
      if (kA == 1 || kA == 23) check("R8", 33'(prepA[31:24]), 33'(kA));
      if (kB == 1 || kB == 23) check("R8", 33'(prepB[31:24]), 33'(kB));
    end
  end

  function automatic logic [31:0] mkNorm();
    logic [7:0] e = 8'($urandom_range(1, 254));
    return {1'($urandom), e, 23'($urandom)};
  endfunction

  function automatic logic [31:0] mkDen();
    logic [22:0] f = 23'($urandom);
    if (f == 0) f = 23'd1;
    f = f >> $urandom_range(0, 22);
    if (f == 0) f = 23'd1;
    return {1'($urandom), 8'd0, f};
  endfunction

  task automatic drive(bit v, logic [31:0] a, bit an, logic [31:0] b, bit bn);
    @(negedge clk);
    inValid = v; opA = a; aNormal = an; opB = b; bNormal = bn;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    drive(1'b1, 32'h3f80_0000, 1'b1, 32'h0000_0001, 1'b0);  // input during reset: R2
    @(negedge clk);
    rstN = 1'b1;
    // R4 both normal
    drive(1'b1, 32'h3f80_0000, 1'b1, 32'hc020_0001, 1'b1);
    // R7/R8 k=1 on A, R6 on B
    drive(1'b1, 32'h8040_0000, 1'b0, 32'h4000_0000, 1'b1);
    // R7/R8 k=23 on B
    drive(1'b1, 32'h7f7f_ffff, 1'b1, 32'h0000_0001, 1'b0);
    // R9 both denormal
    drive(1'b1, 32'h0000_0100, 1'b0, 32'h8000_0003, 1'b0);
    // R10 idle with changing inputs
    drive(1'b0, 32'h0000_0005, 1'b0, 32'h3f80_0000, 1'b1);
    drive(1'b0, 32'hffff_ffff, 1'b1, 32'h0000_0007, 1'b0);
    for (int n = 0; n < 3000; n++) begin
      int kind = $urandom_range(0, 3);
      bit v = ($urandom_range(0, 3) != 0);
      case (kind)
        0: drive(v, mkNorm(), 1'b1, mkNorm(), 1'b1);
        1: drive(v, mkDen(), 1'b0, mkNorm(), 1'b1);
        2: drive(v, mkNorm(), 1'b1, mkDen(), 1'b0);
        default: drive(v, mkDen(), 1'b0, mkDen(), 1'b0);
      endcase
    end
    drive(1'b0, '0, 1'b0, '0, 1'b0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1'b1;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule